// File: doc/BRIEF.md
# SIMT Divergence Reconvergence Stack

This block keeps the control-flow state of one SIMT wavefront while its lanes diverge and later rejoin. Each stack entry holds the PC being executed, the PC at which the diverged paths meet again (the immediate post-dominator), and a mask of the lanes that take part. Branch logic pushes a new entry when a branch splits the lanes. It pops the entry when that path is finished. A PC write that lands on the top entry's reconvergence PC removes that entry on its own.

The block always reports the top entry: its PC, its reconvergence PC and its lane mask. It also gives a lane predicate, which is the top mask ANDed with the mask latched when the wavefront was launched, and the state of any one selected lane. A start command clears the stack and builds the base entry. Sticky flags record a push that was dropped because the stack was full, and a pop that was refused because only the base entry remained. A depth count and an empty indication are also provided.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset the depth is 0, `empty_o` is 1, the PC, reconvergence PC, mask, predicate and lane outputs are 0, and both flags are 0.
- R2: `start_i` sets the depth to 1. The base entry gets PC `start_pc_i`, an all-ones reconvergence PC and mask `launch_mask_i`. The launch mask is latched and both flags are cleared. Start takes priority over every other request in the same cycle.
- R3: A push with no pop, on a stack that is not full, adds an entry {`push_pc_i`, `push_rpc_i`, `push_mask_i`} on top and raises the depth by one. The outputs show the new entry one cycle later.
- R4: A pop with no push, at depth 2 or more, removes the top entry. The outputs return to the entry below it.
- R5: A PC write (`pc_wr_i` alone), whose data differs from the top reconvergence PC or whose depth is 1, replaces only the top PC. The reconvergence PC, mask and depth stay the same.
- R6: A PC write whose data equals the top reconvergence PC, at depth 2 or more, removes the top entry instead of writing it.
- R7: `pred_o` equals `exec_mask_o` AND the latched launch mask, bit by bit.
- R8: `lane_active_o` equals bit `lane_sel_i` of `exec_mask_o`.
- R9: A push with no pop at depth DEPTH (16 by default) is dropped. The entries and depth stay unchanged, and `overflow_o` goes to 1 and stays there until the next start or reset.
- R10: A pop with no push at depth 0 or 1 changes nothing. `underflow_o` goes to 1 and stays there until the next start or reset.
- R11: A push and a pop in the same cycle at depth 1 or more replace the top entry with the pushed one, and the depth does not change. This holds even at full depth. At depth 0 the pair acts as a plain push.
- R12: A PC write in the same cycle as a push or a pop is ignored. Only the push or pop takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch wavefront: clear stack, load base entry |
| start_pc_i | input | PC_W | PC of the base entry |
| launch_mask_i | input | LANES | Lane mask at launch |
| push_i | input | 1 | Push request |
| push_pc_i | input | PC_W | PC of pushed entry |
| push_rpc_i | input | PC_W | Reconvergence PC of pushed entry |
| push_mask_i | input | LANES | Lane mask of pushed entry |
| pop_i | input | 1 | Pop request |
| pc_wr_i | input | 1 | Write top PC |
| pc_wr_data_i | input | PC_W | New PC value |
| lane_sel_i | input | $clog2(LANES) | Lane to query |
| pc_o | output | PC_W | Top PC |
| rpc_o | output | PC_W | Top reconvergence PC |
| exec_mask_o | output | LANES | Top lane mask |
| pred_o | output | LANES | Top mask AND launch mask |
| lane_active_o | output | 1 | Selected lane bit of top mask |
| depth_o | output | $clog2(DEPTH+1) | Entries on the stack |
| empty_o | output | 1 | Depth is zero |
| overflow_o | output | 1 | Sticky dropped-push flag |
| underflow_o | output | 1 | Sticky refused-pop flag |

## Verification
The bench targets these corner cases:
- It fills the stack to sixteen entries and pushes once more. A design with an off-by-one full test would either overwrite beyond the last slot or drop the sixteenth push.
- It pops down to the base entry and past it. A design that lets the base go would show an empty stack with zero outputs instead of keeping the base and raising the underflow flag.
- It issues a combined push and pop, including one at full depth. A design that orders them wrongly would change the depth or raise overflow.
- It issues a PC write equal to the reconvergence PC, and PC writes that collide with a push or pop. A design that ignores reconvergence, or lets a colliding write through, would report a stale PC or a wrong depth.

// File: rtl/simt_rstk_pkg.sv
package simt_rstk_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_START,
    OP_REPLACE,
    OP_PUSH,
    OP_POP,
    OP_PCWR,
    OP_RECONV
  } rstk_op_e;
endpackage

// File: rtl/simt_rstk_ctrl.sv
module simt_rstk_ctrl
  import simt_rstk_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PC_W  = 32,
  localparam int DW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DEPTH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic            pc_wr_i,
  input  logic [PC_W-1:0] pc_wr_data_i,
  input  logic [PC_W-1:0] top_rpc_i,
  output rstk_op_e        op_o,
  output logic            wr_en_o,
  output logic            wr_pc_only_o,
  output logic [IW-1:0]   wr_idx_o,
  output logic [IW-1:0]   top_idx_o,
  output logic [DW-1:0]   depth_o,
  output logic            ovf_o,
  output logic            udf_o
);
  logic [DW-1:0] depth_q, depth_d;
  logic          ovf_q, ovf_d, udf_q, udf_d;
  logic          full;
  rstk_op_e      op;

  assign full      = (depth_q == DW'(DEPTH));
  assign top_idx_o = (depth_q == '0) ? '0 : IW'(depth_q - 1'b1);

  always_comb begin
    op = OP_IDLE;
    if (start_i)                          op = OP_START;
    else if (push_i && pop_i && depth_q != '0) op = OP_REPLACE;
    else if (push_i)                      op = OP_PUSH;
    else if (pop_i)                       op = OP_POP;
    else if (pc_wr_i) begin
      if (depth_q > DW'(1) && pc_wr_data_i == top_rpc_i) op = OP_RECONV;
      else if (depth_q != '0)                            op = OP_PCWR;
    end
  end

  always_comb begin
    depth_d      = depth_q;
    ovf_d        = ovf_q;
    udf_d        = udf_q;
    wr_en_o      = 1'b0;
    wr_pc_only_o = 1'b0;
    wr_idx_o     = top_idx_o;
    unique case (op)
      OP_START: begin
        depth_d  = DW'(1);
        ovf_d    = 1'b0;
        udf_d    = 1'b0;
        wr_en_o  = 1'b1;
        wr_idx_o = '0;
      end
      OP_REPLACE: wr_en_o = 1'b1;
      OP_PUSH: begin
        if (full) ovf_d = 1'b1;
        else begin
          wr_en_o  = 1'b1;
          wr_idx_o = IW'(depth_q);
          depth_d  = depth_q + 1'b1;
        end
      end
      OP_POP: begin
        if (depth_q <= DW'(1)) udf_d = 1'b1;
        else                   depth_d = depth_q - 1'b1;
      end
      OP_RECONV: depth_d = depth_q - 1'b1;
      OP_PCWR: begin
        wr_en_o      = 1'b1;
        wr_pc_only_o = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q <= '0;
      ovf_q   <= 1'b0;
      udf_q   <= 1'b0;
    end else begin
      depth_q <= depth_d;
      ovf_q   <= ovf_d;
      udf_q   <= udf_d;
    end
  end

  assign op_o    = op;
  assign depth_o = depth_q;
  assign ovf_o   = ovf_q;
  assign udf_o   = udf_q;
endmodule

// File: rtl/simt_rstk_store.sv
module simt_rstk_store #(
  parameter int DEPTH = 16,
  parameter int PC_W  = 32,
  parameter int LANES = 64,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_pc_only_i,
  input  logic [IW-1:0]    wr_idx_i,
  input  logic [PC_W-1:0]  wr_pc_i,
  input  logic [PC_W-1:0]  wr_rpc_i,
  input  logic [LANES-1:0] wr_mask_i,
  input  logic [IW-1:0]    rd_idx_i,
  output logic [PC_W-1:0]  rd_pc_o,
  output logic [PC_W-1:0]  rd_rpc_o,
  output logic [LANES-1:0] rd_mask_o
);
  logic [PC_W-1:0]  pc_q   [DEPTH];
  logic [PC_W-1:0]  rpc_q  [DEPTH];
  logic [LANES-1:0] mask_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        pc_q[i]   <= '0;
        rpc_q[i]  <= '0;
        mask_q[i] <= '0;
      end
    end else if (wr_en_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_idx_i == IW'(i)) begin
          pc_q[i] <= wr_pc_i;
          if (!wr_pc_only_i) begin
            rpc_q[i]  <= wr_rpc_i;
            mask_q[i] <= wr_mask_i;
          end
        end
      end
    end
  end

  assign rd_pc_o   = pc_q[rd_idx_i];
  assign rd_rpc_o  = rpc_q[rd_idx_i];
  assign rd_mask_o = mask_q[rd_idx_i];
endmodule

// File: rtl/simt_rstk_view.sv
module simt_rstk_view #(
  parameter int PC_W  = 32,
  parameter int LANES = 64,
  localparam int LW = $clog2(LANES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LANES-1:0] launch_mask_i,
  input  logic             empty_i,
  input  logic [PC_W-1:0]  top_pc_i,
  input  logic [PC_W-1:0]  top_rpc_i,
  input  logic [LANES-1:0] top_mask_i,
  input  logic [LW-1:0]    lane_sel_i,
  output logic [PC_W-1:0]  pc_o,
  output logic [PC_W-1:0]  rpc_o,
  output logic [LANES-1:0] mask_o,
  output logic [LANES-1:0] pred_o,
  output logic             lane_o
);
  logic [LANES-1:0] launch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      launch_q <= '0;
    else if (start_i) launch_q <= launch_mask_i;
  end

  assign pc_o   = empty_i ? '0 : top_pc_i;
  assign rpc_o  = empty_i ? '0 : top_rpc_i;
  assign mask_o = empty_i ? '0 : top_mask_i;
  assign pred_o = mask_o & launch_q;
  assign lane_o = mask_o[lane_sel_i];
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
  import simt_rstk_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PC_W  = 32,
  parameter int LANES = 64,
  localparam int DW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DEPTH),
  localparam int LW = $clog2(LANES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [PC_W-1:0]  start_pc_i,
  input  logic [LANES-1:0] launch_mask_i,
  input  logic             push_i,
  input  logic [PC_W-1:0]  push_pc_i,
  input  logic [PC_W-1:0]  push_rpc_i,
  input  logic [LANES-1:0] push_mask_i,
  input  logic             pop_i,
  input  logic             pc_wr_i,
  input  logic [PC_W-1:0]  pc_wr_data_i,
  input  logic [LW-1:0]    lane_sel_i,
  output logic [PC_W-1:0]  pc_o,
  output logic [PC_W-1:0]  rpc_o,
  output logic [LANES-1:0] exec_mask_o,
  output logic [LANES-1:0] pred_o,
  output logic             lane_active_o,
  output logic [DW-1:0]    depth_o,
  output logic             empty_o,
  output logic             overflow_o,
  output logic             underflow_o
);
  rstk_op_e         op;
  logic             wr_en, wr_pc_only;
  logic [IW-1:0]    wr_idx, top_idx;
  logic [PC_W-1:0]  wr_pc, wr_rpc, top_pc, top_rpc;
  logic [LANES-1:0] wr_mask, top_mask;

  simt_rstk_ctrl #(.DEPTH(DEPTH), .PC_W(PC_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .push_i, .pop_i, .pc_wr_i, .pc_wr_data_i,
    .top_rpc_i(top_rpc), .op_o(op), .wr_en_o(wr_en), .wr_pc_only_o(wr_pc_only),
    .wr_idx_o(wr_idx), .top_idx_o(top_idx), .depth_o, .ovf_o(overflow_o),
    .udf_o(underflow_o)
  );

  always_comb begin
    wr_pc   = push_pc_i;
    wr_rpc  = push_rpc_i;
    wr_mask = push_mask_i;
    if (op == OP_START) begin
      wr_pc   = start_pc_i;
      wr_rpc  = '1;  // base entry never reconverges
      wr_mask = launch_mask_i;
    end else if (op == OP_PCWR) begin
      wr_pc = pc_wr_data_i;
    end
  end

  simt_rstk_store #(.DEPTH(DEPTH), .PC_W(PC_W), .LANES(LANES)) u_store (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_pc_only_i(wr_pc_only),
    .wr_idx_i(wr_idx), .wr_pc_i(wr_pc), .wr_rpc_i(wr_rpc), .wr_mask_i(wr_mask),
    .rd_idx_i(top_idx), .rd_pc_o(top_pc), .rd_rpc_o(top_rpc), .rd_mask_o(top_mask)
  );

  assign empty_o = (depth_o == '0);

  simt_rstk_view #(.PC_W(PC_W), .LANES(LANES)) u_view (
    .clk_i, .rst_ni, .start_i, .launch_mask_i, .empty_i(empty_o),
    .top_pc_i(top_pc), .top_rpc_i(top_rpc), .top_mask_i(top_mask),
    .lane_sel_i, .pc_o, .rpc_o, .mask_o(exec_mask_o), .pred_o,
    .lane_o(lane_active_o)
  );
endmodule

// File: rtl/simt_reconv_stack_chk.sv
module simt_reconv_stack_chk #(
  parameter int DEPTH = 16,
  parameter int PC_W  = 32,
  parameter int LANES = 64,
  localparam int DW = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             push_i,
  input logic             pop_i,
  input logic             pc_wr_i,
  input logic [PC_W-1:0]  pc_wr_data_i,
  input logic [PC_W-1:0]  rpc_o,
  input logic [LANES-1:0] exec_mask_o,
  input logic [LANES-1:0] pred_o,
  input logic [DW-1:0]    depth_o,
  input logic             overflow_o,
  input logic             underflow_o
);
  a_r9_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !start_i && depth_o == DW'(DEPTH))
      |=> (overflow_o && $stable(depth_o)));

  a_r10_underflow_keeps_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !start_i && depth_o <= DW'(1))
      |=> (underflow_o && $stable(depth_o)));

  a_r3_push_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !start_i && depth_o < DW'(DEPTH))
      |=> (depth_o == $past(depth_o) + 1'b1));

  a_r5_pc_write_keeps_rest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_wr_i && !push_i && !pop_i && !start_i && depth_o != '0 && pc_wr_data_i != rpc_o)
      |=> ($stable(rpc_o) && $stable(exec_mask_o) && $stable(depth_o)));

  a_r11_replace_keeps_depth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !start_i && depth_o != '0) |=> $stable(depth_o));

  a_r9_overflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && !start_i) |=> overflow_o);

  a_r2_start_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (depth_o == DW'(1) && rpc_o == '1 && !overflow_o && !underflow_o));

  always_comb begin
    if (rst_ni) a_r7_pred_in_mask: assert ((pred_o & ~exec_mask_o) == '0);
  end
endmodule

bind simt_reconv_stack simt_reconv_stack_chk #(.DEPTH(DEPTH), .PC_W(PC_W), .LANES(LANES)) u_chk (
  .clk_i, .rst_ni, .start_i, .push_i, .pop_i, .pc_wr_i, .pc_wr_data_i,
  .rpc_o, .exec_mask_o, .pred_o, .depth_o, .overflow_o, .underflow_o
);

// File: tb/simt_reconv_stack_bench.sv
`timescale 1ns/1ps
module simt_reconv_stack_bench;
  localparam int DEPTH = 16;
  localparam int PC_W  = 32;
  localparam int LANES = 64;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 0, push_i = 0, pop_i = 0, pc_wr_i = 0;
  logic [PC_W-1:0]  start_pc_i = '0, push_pc_i = '0, push_rpc_i = '0, pc_wr_data_i = '0;
  logic [LANES-1:0] launch_mask_i = '0, push_mask_i = '0;
  logic [5:0]       lane_sel_i = '0;
  logic [PC_W-1:0]  pc_o, rpc_o;
  logic [LANES-1:0] exec_mask_o, pred_o;
  logic             lane_active_o, empty_o, overflow_o, underflow_o;
  logic [4:0]       depth_o;

  always #2.5 clk = ~clk;

  simt_reconv_stack u_simt_reconv_stack (
    .clk_i(clk), .rst_ni, .start_i, .start_pc_i, .launch_mask_i, .push_i,
    .push_pc_i, .push_rpc_i, .push_mask_i, .pop_i, .pc_wr_i, .pc_wr_data_i,
    .lane_sel_i, .pc_o, .rpc_o, .exec_mask_o, .pred_o, .lane_active_o,
    .depth_o, .empty_o, .overflow_o, .underflow_o
  );

  typedef struct {
    logic [31:0] pc, rpc;
    logic [63:0] mask, pred;
    logic        lane, empty, ovf, udf;
    int          depth;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int errors = 0, checks = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_pc [DEPTH], m_rpc [DEPTH];
  logic [63:0] m_mask [DEPTH];
  logic [63:0] m_launch = '0;
  int m_depth = 0;
  bit m_ovf = 0, m_udf = 0;

  task automatic chk(string tag, string f, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, f, act, expv);
    end
  endtask

  task automatic chk_all(exp_t e);
    chk(e.tag, "pc", 64'(pc_o), 64'(e.pc));
    chk(e.tag, "rpc", 64'(rpc_o), 64'(e.rpc));
    chk(e.tag, "mask", exec_mask_o, e.mask);
    chk(e.tag, "pred", pred_o, e.pred);
    chk(e.tag, "lane", 64'(lane_active_o), 64'(e.lane));
    chk(e.tag, "depth", 64'(depth_o), 64'(e.depth));
    chk(e.tag, "empty", 64'(empty_o), 64'(e.empty));
    chk(e.tag, "ovf", 64'(overflow_o), 64'(e.ovf));
    chk(e.tag, "udf", 64'(underflow_o), 64'(e.udf));
  endtask

  function automatic exp_t snap(int lane, string tag);
    exp_t e;
    int t = m_depth - 1;
    e.empty = (m_depth == 0);
    e.pc    = e.empty ? '0 : m_pc[t];
    e.rpc   = e.empty ? '0 : m_rpc[t];
    e.mask  = e.empty ? '0 : m_mask[t];
    e.pred  = e.mask & m_launch;
    e.lane  = e.mask[lane];
    e.depth = m_depth;
    e.ovf   = m_ovf;
    e.udf   = m_udf;
    e.tag   = tag;
    return e;
  endfunction

  // driver: apply one cycle of requests and predict the result
  task automatic op(bit st, bit ps, bit pp, bit pw, logic [31:0] a, logic [31:0] b,
                    logic [63:0] m, int lane, string tag);
    @(negedge clk);
    start_i = st; push_i = ps; pop_i = pp; pc_wr_i = pw;
    start_pc_i = a; push_pc_i = a; pc_wr_data_i = a; push_rpc_i = b;
    push_mask_i = m; launch_mask_i = m; lane_sel_i = 6'(lane);
    if (st) begin
      m_depth = 1; m_pc[0] = a; m_rpc[0] = '1; m_mask[0] = m;
      m_launch = m; m_ovf = 0; m_udf = 0;
    end else if (ps && pp && m_depth > 0) begin
      m_pc[m_depth-1] = a; m_rpc[m_depth-1] = b; m_mask[m_depth-1] = m;
    end else if (ps) begin
      if (m_depth == DEPTH) m_ovf = 1;
      else begin
        m_pc[m_depth] = a; m_rpc[m_depth] = b; m_mask[m_depth] = m; m_depth++;
      end
    end else if (pp) begin
      if (m_depth <= 1) m_udf = 1; else m_depth--;
    end else if (pw) begin
      if (m_depth > 1 && a == m_rpc[m_depth-1]) m_depth--;
      else if (m_depth > 0) m_pc[m_depth-1] = a;
    end
    exp_q.push_back(snap(lane, tag));
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) chk_all(exp_q.pop_front());
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_all(snap(0, "R1 reset"));
    rst_ni = 1'b1;
    // R10 pop on empty stack
    op(0,0,1,0, 32'h0, 32'h0, 64'h0, 0, "R10 pop empty");
    // R11 push+pop on empty acts as push
    op(0,1,1,0, 32'h40, 32'h80, 64'hF0, 4, "R11 pair on empty");
    // R2 start clears flags, start wins over push
    op(1,1,0,0, 32'h100, 32'h0, 64'hFFFF_0000_FFFF_00FF, 8, "R2 start");
    // R3 push, R7 predicate, R8 lane query
    op(0,1,0,0, 32'h104, 32'h200, 64'hFFFF_FFFF_0000_0000, 40, "R3 push");
    op(0,1,0,0, 32'h108, 32'h180, 64'h0000_00FF_0000_0000, 33, "R7 pred");
    op(0,0,0,0, 32'h0, 32'h0, 64'h0, 31, "R8 lane query");
    // R5 pc write only changes pc
    op(0,0,0,1, 32'h10C, 32'h0, 64'h0, 32, "R5 pc write");
    // R6 pc write hitting rpc pops
    op(0,0,0,1, 32'h180, 32'h0, 64'h0, 40, "R6 reconverge");
    // R12 pc write with push ignored
    op(0,1,0,1, 32'h300, 32'h340, 64'h5555, 0, "R12 pc write with push");
    // R4 pop restores lower entry
    op(0,0,1,1, 32'h999, 32'h0, 64'h0, 48, "R4 pop");
    // R11 replace top
    op(0,1,1,0, 32'h500, 32'h600, 64'hAAAA_0000, 17, "R11 replace");
    // R5 pc write at base with all-ones sentinel present
    op(0,0,1,0, 32'h0, 32'h0, 64'h0, 0, "R4 back to base");
    op(0,0,0,1, 32'h120, 32'h0, 64'h0, 0, "R5 base pc write");
    // fill to full
    for (int i = 1; i < DEPTH; i++)
      op(0,1,0,0, 32'h1000 + 32'(i), 32'h2000 + 32'(i), 64'(i) << i, i, "R3 fill");
    op(0,1,0,0, 32'hDEAD, 32'hBEEF, 64'h1, 0, "R9 push when full");
    op(0,1,1,0, 32'h7777, 32'h8888, 64'h3, 1, "R11 replace at full");
    op(0,0,0,0, 32'h0, 32'h0, 64'h0, 2, "R9 sticky");
    for (int i = 1; i < DEPTH; i++)
      op(0,0,1,0, 32'h0, 32'h0, 64'h0, i, "R4 drain");
    op(0,0,1,0, 32'h0, 32'h0, 64'h0, 5, "R10 pop at base");
    op(0,0,0,0, 32'h0, 32'h0, 64'h0, 6, "R10 sticky");
    op(1,0,1,1, 32'h4000, 32'h0, 64'hF, 3, "R2 restart clears flags");
    op(0,0,0,0, 32'h0, 32'h0, 64'h0, 7, "R8 idle");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule